// File: doc/BRIEF.md
# Serial Display RAM Write Port

This block is the input side of a graphic display controller. A host drives a write-only serial link made of a data line, a shift clock, an active-low chip enable and a data/command select. The block assembles each group of eight bits into a byte. A data byte becomes a single write strobe into a display memory of six banks by eighty-four columns. A command byte updates the controller's flags, its display-mode bits, or one of its two address registers.

The address points at one byte of the memory. The bank index is the vertical coordinate and the column index is the horizontal one. The column index maps straight onto a display column. After each data write the address moves forward by one. A direction flag decides whether it moves along columns first (horizontal mode) or along banks first (vertical mode). The memory array itself lies outside the block and sees only the write port.

The serial signals are level inputs sampled by the system clock. A rising shift-clock edge is detected inside the block. Reset is synchronous and active high.

Top module: `serial_disp_wr`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is: column 0, bank 0, `pwr_down`=1, `vert_mode`=0, `ext_set`=0, `disp_d`=0 and `disp_e`=0.
- R2: While `ser_cs_n` is low, each rising edge of `ser_clk` shifts in one bit of `ser_din`, most significant bit first. The eighth edge completes a byte. While `ser_cs_n` is high, shift-clock edges have no effect.
- R3: If `ser_cs_n` goes high before the eighth edge, the partial byte is discarded. The next byte framing then starts from bit zero.
- R4: A completed byte with `ser_dc`=1 (sampled on the eighth edge) gives exactly one cycle of `mem_we`. That write carries the byte on `mem_wdata` and the current bank and column on `mem_bank` and `mem_col`. A byte with `ser_dc`=0 never asserts `mem_we`.
- R5: In horizontal mode (`vert_mode`=0), a write advances the column by one. From column 83 the column returns to 0 and the bank advances by one, returning from bank 5 to bank 0.
- R6: In vertical mode (`vert_mode`=1), a write advances the bank by one. From bank 5 the bank returns to 0 and the column advances by one, returning from 83 to 0.
- R7: Command `0010_0PVH` is decoded whatever the value of `ext_set`. It loads `pwr_down` from bit 2, `vert_mode` from bit 1 and `ext_set` from bit 0.
- R8: With `ext_set`=0, command `0000_1D0E` loads `disp_d` from bit 2 and `disp_e` from bit 0.
- R9: With `ext_set`=0, command `0100_0yyy` loads the bank from bits 2..0, and command `1xxx_xxxx` loads the column from bits 6..0. A bank value above 5 or a column value above 83 loads 0 instead.
- R10: With `ext_set`=1, the bank, column and display-mode commands are ignored. The address and `disp_d`/`disp_e` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock (level, sampled by clk) |
| ser_din | input | 1 | Serial data bit |
| ser_cs_n | input | 1 | Active-low chip enable |
| ser_dc | input | 1 | 1 = data byte, 0 = command byte |
| mem_we | output | 1 | One-cycle display memory write strobe |
| mem_bank | output | 3 | Current bank address (0..5) |
| mem_col | output | 7 | Current column address (0..83) |
| mem_wdata | output | 8 | Byte written to memory |
| pwr_down | output | 1 | Power-down flag |
| vert_mode | output | 1 | Addressing direction, 1 = vertical |
| ext_set | output | 1 | Extended instruction set selected |
| disp_d | output | 1 | Display mode bit D |
| disp_e | output | 1 | Display mode bit E |

## Verification
The stepping assertions rely on two completed bytes being at least eight shift-clock edges apart. Because of that gap, a write strobe is never followed in the next cycle by another byte event. The stimulus holds each shift-clock level for two system clocks, which keeps that spacing. It also drives `ser_cs_n`, `ser_dc` and `ser_din` only while the shift clock is low. The assertions also take it that no command and no write land in the same cycle, which follows because the block produces only one byte event at a time.

// File: rtl/dispwr_pkg.sv
package dispwr_pkg;

    localparam int DEF_COLS  = 84;
    localparam int DEF_BANKS = 6;
    localparam int BYTE_W    = 8;
    localparam int BITCNT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        OP_NONE,
        OP_FUNC,
        OP_DISP,
        OP_SETY,
        OP_SETX
    } op_e;

    typedef struct packed {
        logic pd;
        logic vert;
        logic ext;
    } func_t;

    typedef struct packed {
        logic d;
        logic e;
    } disp_t;

    typedef struct packed {
        logic              valid;
        logic              is_data;
        logic [BYTE_W-1:0] value;
    } byte_ev_t;

    // Command classification: function set is visible in both sets,
    // address and display commands only in the basic set.
    function automatic op_e classify(input logic [BYTE_W-1:0] b, input logic ext);
        op_e op;
        op = OP_NONE;
        if (b[7:3] == 5'b00100) begin
            op = OP_FUNC;
        end else if (!ext) begin
            if (b[7]) begin
                op = OP_SETX;
            end else if (b[7:3] == 5'b01000) begin
                op = OP_SETY;
            end else if (b[7:3] == 5'b00001 && !b[1]) begin
                op = OP_DISP;
            end
        end
        return op;
    endfunction

endpackage

// File: rtl/dispwr_shift_in.sv
module dispwr_shift_in
    import dispwr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ser_clk,
    input  logic     ser_din,
    input  logic     ser_cs_n,
    input  logic     ser_dc,
    output byte_ev_t ev
);

    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W - 1);

    logic                clk_prev;
    logic                rise;
    logic [BITCNT_W-1:0] bit_cnt;
    logic [BYTE_W-2:0]   shreg;
    byte_ev_t            ev_q;

    assign rise = ser_clk & ~clk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_prev <= 1'b1;
            bit_cnt  <= '0;
            shreg    <= '0;
            ev_q     <= '0;
        end else begin
            clk_prev    <= ser_clk;
            ev_q.valid  <= 1'b0;
            if (ser_cs_n) begin
                bit_cnt <= '0;
            end else if (rise) begin
                if (bit_cnt == LAST_BIT) begin
                    ev_q.valid   <= 1'b1;
                    ev_q.is_data <= ser_dc;
                    ev_q.value   <= {shreg, ser_din};
                    bit_cnt      <= '0;
                end else begin
                    shreg   <= {shreg[BYTE_W-3:0], ser_din};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    assign ev = ev_q;

endmodule

// File: rtl/dispwr_cmd_dec.sv
module dispwr_cmd_dec
    import dispwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  byte_ev_t          ev,
    output func_t             func,
    output disp_t             disp,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_data,
    output logic              load_x,
    output logic              load_y,
    output logic [6:0]        x_field,
    output logic [2:0]        y_field
);

    op_e   op;
    logic  cmd_ev;
    func_t func_q;
    disp_t disp_q;

    assign cmd_ev  = ev.valid & ~ev.is_data;
    assign op      = cmd_ev ? classify(ev.value, func_q.ext) : OP_NONE;

    assign wr_stb  = ev.valid & ev.is_data;
    assign wr_data = ev.value;
    assign load_x  = (op == OP_SETX);
    assign load_y  = (op == OP_SETY);
    assign x_field = ev.value[6:0];
    assign y_field = ev.value[2:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            func_q <= '{pd: 1'b1, vert: 1'b0, ext: 1'b0};
            disp_q <= '{d: 1'b0, e: 1'b0};
        end else begin
            case (op)
                OP_FUNC: func_q <= '{pd: ev.value[2], vert: ev.value[1], ext: ev.value[0]};
                OP_DISP: disp_q <= '{d: ev.value[2], e: ev.value[0]};
                default: ;
            endcase
        end
    end

    assign func = func_q;
    assign disp = disp_q;

endmodule

// File: rtl/dispwr_addr_ctr.sv
module dispwr_addr_ctr #(
    parameter int NUM_COLS  = dispwr_pkg::DEF_COLS,
    parameter int NUM_BANKS = dispwr_pkg::DEF_BANKS,
    localparam int COL_W    = $clog2(NUM_COLS),
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              vert,
    input  logic              load_x,
    input  logic              load_y,
    input  logic [6:0]        x_field,
    input  logic [2:0]        y_field,
    output logic [COL_W-1:0]  col,
    output logic [BANK_W-1:0] bank
);

    localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(NUM_COLS - 1);
    localparam logic [BANK_W-1:0] BANK_LAST = BANK_W'(NUM_BANKS - 1);

    logic [COL_W-1:0]  col_q;
    logic [BANK_W-1:0] bank_q;
    logic [COL_W-1:0]  col_inc;
    logic [BANK_W-1:0] bank_inc;
    logic              col_wrap;
    logic              bank_wrap;

    assign col_wrap  = (col_q == COL_LAST);
    assign bank_wrap = (bank_q == BANK_LAST);
    assign col_inc   = col_wrap  ? '0 : col_q + 1'b1;
    assign bank_inc  = bank_wrap ? '0 : bank_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q  <= '0;
            bank_q <= '0;
        end else if (step) begin
            if (!vert) begin
                col_q <= col_inc;
                if (col_wrap) bank_q <= bank_inc;
            end else begin
                bank_q <= bank_inc;
                if (bank_wrap) col_q <= col_inc;
            end
        end else begin
            if (load_x) col_q  <= (int'(x_field) < NUM_COLS)  ? COL_W'(x_field)  : '0;
            if (load_y) bank_q <= (int'(y_field) < NUM_BANKS) ? BANK_W'(y_field) : '0;
        end
    end

    assign col  = col_q;
    assign bank = bank_q;

endmodule

// File: rtl/serial_disp_wr.sv
module serial_disp_wr
    import dispwr_pkg::*;
#(
    parameter int NUM_COLS  = DEF_COLS,
    parameter int NUM_BANKS = DEF_BANKS,
    localparam int COL_W    = $clog2(NUM_COLS),
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              ser_cs_n,
    input  logic              ser_dc,
    output logic              mem_we,
    output logic [BANK_W-1:0] mem_bank,
    output logic [COL_W-1:0]  mem_col,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              pwr_down,
    output logic              vert_mode,
    output logic              ext_set,
    output logic              disp_d,
    output logic              disp_e
);

    byte_ev_t   ev;
    func_t      func;
    disp_t      disp;
    logic       wr_stb;
    logic       load_x;
    logic       load_y;
    logic [6:0] x_field;
    logic [2:0] y_field;

    dispwr_shift_in u_shift (
        .clk      (clk),
        .rst      (rst),
        .ser_clk  (ser_clk),
        .ser_din  (ser_din),
        .ser_cs_n (ser_cs_n),
        .ser_dc   (ser_dc),
        .ev       (ev)
    );

    dispwr_cmd_dec u_dec (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .func    (func),
        .disp    (disp),
        .wr_stb  (wr_stb),
        .wr_data (mem_wdata),
        .load_x  (load_x),
        .load_y  (load_y),
        .x_field (x_field),
        .y_field (y_field)
    );

    dispwr_addr_ctr #(
        .NUM_COLS  (NUM_COLS),
        .NUM_BANKS (NUM_BANKS)
    ) u_addr (
        .clk     (clk),
        .rst     (rst),
        .step    (wr_stb),
        .vert    (func.vert),
        .load_x  (load_x),
        .load_y  (load_y),
        .x_field (x_field),
        .y_field (y_field),
        .col     (mem_col),
        .bank    (mem_bank)
    );

    assign mem_we    = wr_stb;
    assign pwr_down  = func.pd;
    assign vert_mode = func.vert;
    assign ext_set   = func.ext;
    assign disp_d    = disp.d;
    assign disp_e    = disp.e;

endmodule

// File: rtl/serial_disp_wr_chk.sv
module serial_disp_wr_chk #(
    parameter int NUM_COLS  = 84,
    parameter int NUM_BANKS = 6,
    localparam int COL_W    = $clog2(NUM_COLS),
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_we,
    input logic [BANK_W-1:0] mem_bank,
    input logic [COL_W-1:0]  mem_col,
    input logic              pwr_down,
    input logic              vert_mode,
    input logic              ext_set,
    input logic              disp_d,
    input logic              disp_e
);

    localparam logic [COL_W-1:0]  CL = COL_W'(NUM_COLS - 1);
    localparam logic [BANK_W-1:0] BL = BANK_W'(NUM_BANKS - 1);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (mem_col == '0 && mem_bank == '0 && pwr_down && !vert_mode
                 && !ext_set && !disp_d && !disp_e)); // R1

    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we); // R4

    AST_COL_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(mem_col) < NUM_COLS); // R9

    AST_BANK_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(mem_bank) < NUM_BANKS); // R9

    AST_HORIZ_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !vert_mode && mem_col != CL)
        |=> (mem_col == $past(mem_col) + 1'b1 && $stable(mem_bank))); // R5

    AST_HORIZ_WRAP: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !vert_mode && mem_col == CL)
        |=> (mem_col == '0 && mem_bank == (($past(mem_bank) == BL) ? '0 : $past(mem_bank) + 1'b1))); // R5

    AST_VERT_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_we && vert_mode && mem_bank != BL)
        |=> (mem_bank == $past(mem_bank) + 1'b1 && $stable(mem_col))); // R6

    AST_VERT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (mem_we && vert_mode && mem_bank == BL)
        |=> (mem_bank == '0 && mem_col == (($past(mem_col) == CL) ? '0 : $past(mem_col) + 1'b1))); // R6

    AST_EXT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ext_set && !mem_we)
        |=> ($stable(mem_col) && $stable(mem_bank) && $stable(disp_d) && $stable(disp_e))); // R10

endmodule

bind serial_disp_wr serial_disp_wr_chk #(
    .NUM_COLS  (NUM_COLS),
    .NUM_BANKS (NUM_BANKS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_we    (mem_we),
    .mem_bank  (mem_bank),
    .mem_col   (mem_col),
    .pwr_down  (pwr_down),
    .vert_mode (vert_mode),
    .ext_set   (ext_set),
    .disp_d    (disp_d),
    .disp_e    (disp_e)
);

// File: tb/serial_disp_wr_bench.sv
`timescale 1ns/1ps
module serial_disp_wr_bench;

    localparam int COLS  = 84;
    localparam int BANKS = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_din = 1'b0;
    logic       ser_cs_n = 1'b1;
    logic       ser_dc = 1'b0;
    logic       mem_we;
    logic [2:0] mem_bank;
    logic [6:0] mem_col;
    logic [7:0] mem_wdata;
    logic       pwr_down, vert_mode, ext_set, disp_d, disp_e;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int         wr_count = 0;
    int         last_bank, last_col, last_data;

    always #2 clk = ~clk;

    serial_disp_wr u_serial_disp_wr (
        .clk, .rst, .ser_clk, .ser_din, .ser_cs_n, .ser_dc,
        .mem_we, .mem_bank, .mem_col, .mem_wdata,
        .pwr_down, .vert_mode, .ext_set, .disp_d, .disp_e
    );

    always @(negedge clk) begin
        if (mem_we) begin
            wr_count  <= wr_count + 1;
            last_bank <= int'(mem_bank);
            last_col  <= int'(mem_col);
            last_data <= int'(mem_wdata);
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n, input logic dc);
        ser_cs_n = 1'b0;
        ser_dc   = dc;
        for (int i = 0; i < n; i++) begin
            ser_clk = 1'b0;
            ser_din = b[7-i];
            idle(2);
            ser_clk = 1'b1;
            idle(2);
        end
        ser_clk  = 1'b0;
        idle(1);
        ser_cs_n = 1'b1;
        idle(3);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic dc);
        send_bits(b, 8, dc);
    endtask

    task automatic chk_state(input string req, input int col, input int bank,
                             input int pd, input int v, input int h, input int d, input int e);
        chk(req, "col", int'(mem_col), col);
        chk(req, "bank", int'(mem_bank), bank);
        chk(req, "pd", int'(pwr_down), pd);
        chk(req, "vert", int'(vert_mode), v);
        chk(req, "ext", int'(ext_set), h);
        chk(req, "disp_d", int'(disp_d), d);
        chk(req, "disp_e", int'(disp_e), e);
    endtask

    initial begin
        int w0;
        idle(4);
        // R1: defaults out of reset
        chk_state("R1", 0, 0, 1, 0, 0, 0, 0);
        chk("R1", "we", int'(mem_we), 0);
        rst = 1'b0;
        idle(2);

        // R7: function set, power up, horizontal, basic set
        send_byte(8'h20, 1'b0);
        chk_state("R7", 0, 0, 0, 0, 0, 0, 0);
        send_byte(8'h26, 1'b0);
        chk_state("R7", 0, 0, 1, 1, 0, 0, 0);
        send_byte(8'h20, 1'b0);

        // R8: display control
        send_byte(8'h0C, 1'b0);
        chk("R8", "disp_d", int'(disp_d), 1);
        chk("R8", "disp_e", int'(disp_e), 0);
        send_byte(8'h09, 1'b0);
        chk("R8", "disp_d", int'(disp_d), 0);
        chk("R8", "disp_e", int'(disp_e), 1);

        // R9: address loads and clamping
        send_byte(8'h80 | 8'd83, 1'b0);
        send_byte(8'h45, 1'b0);
        chk("R9", "col", int'(mem_col), 83);
        chk("R9", "bank", int'(mem_bank), 5);
        send_byte(8'h80 | 8'd84, 1'b0);
        send_byte(8'h46, 1'b0);
        chk("R9", "col clamp", int'(mem_col), 0);
        chk("R9", "bank clamp", int'(mem_bank), 0);
        send_byte(8'h80 | 8'd127, 1'b0);
        chk("R9", "col clamp max", int'(mem_col), 0);
        send_byte(8'h80 | 8'd10, 1'b0);
        send_byte(8'h47, 1'b0);
        chk("R9", "col", int'(mem_col), 10);
        chk("R9", "bank clamp max", int'(mem_bank), 0);
        send_byte(8'h42, 1'b0);
        chk("R9", "bank", int'(mem_bank), 2);

        // R4: command bytes never write
        chk("R4", "writes after commands", wr_count, 0);

        // R2, R4: data byte MSB first at current address
        send_byte(8'hA5, 1'b1);
        chk("R4", "write count", wr_count, 1);
        chk("R2", "wdata msb-first", last_data, 8'hA5);
        chk("R4", "write col", last_col, 10);
        chk("R4", "write bank", last_bank, 2);

        // R2: shift-clock edges with chip enable high do nothing
        w0 = wr_count;
        ser_dc = 1'b1;
        for (int i = 0; i < 16; i++) begin
            ser_clk = 1'b1; idle(2);
            ser_clk = 1'b0; idle(2);
        end
        chk("R2", "writes with cs high", wr_count, w0);
        chk("R2", "col unchanged", int'(mem_col), 11);

        // R3: partial byte discarded
        send_bits(8'hFF, 5, 1'b1);
        chk("R3", "no write from partial", wr_count, w0);
        send_byte(8'h80 | 8'd5, 1'b0);
        chk("R3", "next byte framed fresh", int'(mem_col), 5);
        chk("R3", "no write after command", wr_count, w0);

        // R10: extended set ignores address/display commands
        send_byte(8'h21, 1'b0);
        chk("R10", "ext", int'(ext_set), 1);
        send_byte(8'h80 | 8'd40, 1'b0);
        send_byte(8'h43, 1'b0);
        send_byte(8'h0C, 1'b0);
        chk("R10", "col held", int'(mem_col), 5);
        chk("R10", "bank held", int'(mem_bank), 2);
        chk("R10", "disp_d held", int'(disp_d), 0);
        chk("R10", "disp_e held", int'(disp_e), 1);
        send_byte(8'h20, 1'b0);
        chk("R7", "ext cleared from ext set", int'(ext_set), 0);

        // R5: full horizontal sweep from (0,0), wraps back to start
        send_byte(8'h80, 1'b0);
        send_byte(8'h40, 1'b0);
        for (int k = 0; k < COLS * BANKS; k++) begin
            logic [7:0] dv;
            dv = 8'((k * 7 + 3) & 255);
            w0 = wr_count;
            send_byte(dv, 1'b1);
            chk("R4", "one write", wr_count, w0 + 1);
            chk("R5", "h bank", last_bank, k / COLS);
            chk("R5", "h col", last_col, k % COLS);
            chk("R2", "h data", last_data, int'(dv));
        end
        chk("R5", "h wrap col", int'(mem_col), 0);
        chk("R5", "h wrap bank", int'(mem_bank), 0);

        // R6: full vertical sweep from (0,0)
        send_byte(8'h22, 1'b0);
        chk("R7", "vert", int'(vert_mode), 1);
        for (int k = 0; k < COLS * BANKS; k++) begin
            logic [7:0] dv;
            dv = 8'((k * 13 + 91) & 255);
            send_byte(dv, 1'b1);
            chk("R6", "v bank", last_bank, k % BANKS);
            chk("R6", "v col", last_col, k / BANKS);
            chk("R2", "v data", last_data, int'(dv));
        end
        chk("R6", "v wrap col", int'(mem_col), 0);
        chk("R6", "v wrap bank", int'(mem_bank), 0);

        // R1: reset in mid-operation restores defaults
        send_byte(8'h80 | 8'd30, 1'b0);
        send_byte(8'h0C, 1'b0);
        rst = 1'b1;
        idle(2);
        chk_state("R1", 0, 0, 1, 0, 0, 0, 0);
        rst = 1'b0;
        idle(2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule